// File: doc/BRIEF.md
# Serial Slave Interface with Transfer Pause

This block is the bit-level front-end of a serial-peripheral slave for a memory-style device. It receives a select line, a serial clock, a data input and an active-low pause input from the pins, and drives a data output together with an output enable. The output enable lets a pad cell place the line in high impedance. Incoming bits are assembled into bytes and handed to the user side as a parallel byte with a one-cycle valid strobe. The user side supplies the byte to be shifted out next.

All pin inputs are asynchronous. They are brought into a system clock domain that runs at least four times faster than the serial clock, and every edge is detected there.

A pause, or hold, can stop a transfer part-way through. While it lasts, the output is released and both the serial clock and the data input are ignored. When the pause ends, shifting continues from the exact bit where it stopped. Pause entry and exit are only accepted while the serial clock is low. A request made while the clock is high is deferred to the next falling edge of the clock. Deselecting the slave during a pause abandons the transfer.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, and at any time the select input `sel_n_i` is high, `q_en_o` is 0, `rx_valid_o` is 0 and the bit position is cleared, so the next transfer starts at bit 7; after reset `rx_byte_o` is 0.
- R2: `d_i` is sampled on each rising edge of `sclk_i`, most significant bit first. After the eighth rising edge of a byte, `rx_byte_o` holds the assembled byte and `rx_valid_o` is 1 for exactly one system clock cycle.
- R3: While the slave is selected and not paused, `q_en_o` is 1. `q_o` carries bit 7 of the transmit byte from selection onward and advances to the next lower bit after each falling edge of `sclk_i`.
- R4: `tx_byte_i` is followed continuously while the slave is deselected. During a transfer it is sampled again at the falling edge of `sclk_i` that follows the eighth rising edge of a byte, and its bit 7 appears on `q_o` next.
- R5: With the slave selected, `hold_n_i` low and `sclk_i` low, the slave is paused. During the pause `q_en_o` is 0, and pulses on `sclk_i` and changes on `d_i` have no effect.
- R6: A pause keeps the bit position and the shift contents. After release, the received byte and the output bits continue exactly where they stopped.
- R7: If `hold_n_i` falls while `sclk_i` is high, the pause starts at the next falling edge of `sclk_i`. That falling edge still advances `q_o`.
- R8: If `hold_n_i` rises while `sclk_i` is high, `q_en_o` stays 0 until the next falling edge of `sclk_i` releases the pause. That falling edge does not advance `q_o`.
- R9: Taking `sel_n_i` high during a pause abandons the partial byte without a strobe. The next transfer starts again from bit 7.
- R10: Activity on `hold_n_i`, `sclk_i` and `d_i` while `sel_n_i` is high produces no strobe and keeps `q_en_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Slave select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles low |
| d_i | input | 1 | Serial data input |
| hold_n_i | input | 1 | Pause request, active low |
| q_o | output | 1 | Serial data output value |
| q_en_o | output | 1 | Output enable for the serial data pad |
| rx_byte_o | output | 8 | Last byte received |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| tx_byte_i | input | 8 | Next byte to shift out |

## Verification
The hardest cases to reach from the ports are the deferred pause transitions. In these, the pause input moves while the serial clock is high, so the transition lands on a falling edge of the clock. That edge must advance the output on entry and must not advance it on exit. The stimulus changes `hold_n_i` in the middle of a high clock phase and toggles the clock while paused. It then checks the reassembled byte and every output bit against the untouched values. A deselect issued while paused is followed by a fresh full byte, which shows that no stale bits remain.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        LINK_IDLE   = 2'd0,
        LINK_ACTIVE = 2'd1,
        LINK_PAUSED = 2'd2
    } link_state_e;

    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic data;
        logic hold_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sclk: 1'b0, data: 1'b0, hold_n: 1'b1};

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur, input logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int          W        = 4,
    parameter int          STAGES   = 2,
    parameter logic [W-1:0] INIT    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= INIT;
                else     stage_q[s] <= async_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= INIT;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_n_s,
    input  logic        sclk_s,
    input  logic        hold_n_s,
    output link_state_e state_o,
    output logic        rise_o,
    output logic        fall_o,
    output logic        clear_o
);
    link_state_e state_q, state_d;
    logic        sclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    always_comb begin
        state_d = state_q;
        if (sel_n_s) begin
            state_d = LINK_IDLE;
        end else begin
            unique case (state_q)
                LINK_IDLE:   state_d = LINK_ACTIVE;
                LINK_ACTIVE: if (!sclk_s && !hold_n_s) state_d = LINK_PAUSED;
                LINK_PAUSED: if (!sclk_s &&  hold_n_s) state_d = LINK_ACTIVE;
                default:     state_d = LINK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LINK_IDLE;
        else     state_q <= state_d;
    end

    // Edges only count in the active state; a deferred pause entry still
    // lets the qualifying falling edge through since state is still active.
    assign rise_o  = (state_q == LINK_ACTIVE) &&  sclk_s && !sclk_prev_q;
    assign fall_o  = (state_q == LINK_ACTIVE) && !sclk_s &&  sclk_prev_q;
    assign clear_o = sel_n_s;
    assign state_o = state_q;
endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter
    import spi_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              data_s,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              q_bit_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic [BYTE_W-1:0] tx_shift_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] rx_shift_q;
    logic [BYTE_W-1:0] tx_shift_q;
    logic [BYTE_W-1:0] rx_next;

    assign rx_next = shift_in(rx_shift_q, data_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte_o <= '0;
        end else if (!clear_i && rise_i && bit_cnt_q == LAST_BIT) begin
            rx_byte_o <= rx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            bit_cnt_q  <= '0;
            rx_shift_q <= '0;
            rx_valid_o <= 1'b0;
            tx_shift_q <= tx_byte_i;
        end else begin
            rx_valid_o <= 1'b0;
            if (rise_i) begin
                rx_shift_q <= rx_next;
                if (bit_cnt_q == LAST_BIT) begin
                    bit_cnt_q  <= '0;
                    rx_valid_o <= 1'b1;
                end else begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
            if (fall_i) begin
                if (bit_cnt_q == '0) tx_shift_q <= tx_byte_i;
                else                 tx_shift_q <= {tx_shift_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign q_bit_o    = tx_shift_q[BYTE_W-1];
    assign bit_cnt_o  = bit_cnt_q;
    assign tx_shift_o = tx_shift_q;
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              d_i,
    input  logic              hold_n_i,
    output logic              q_o,
    output logic              q_en_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    input  logic [BYTE_W-1:0] tx_byte_i
);
    pins_t             pins_raw, pins_s;
    logic              sel_n_s, sclk_s, data_s, hold_n_s;
    link_state_e       link_state;
    logic              edge_rise, edge_fall, clear;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] tx_shift;

    assign pins_raw = '{sel_n: sel_n_i, sclk: sclk_i, data: d_i, hold_n: hold_n_i};

    spi_hold_sync #(
        .W      ($bits(pins_t)),
        .STAGES (SYNC_STAGES),
        .INIT   (PINS_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    assign sel_n_s  = pins_s.sel_n;
    assign sclk_s   = pins_s.sclk;
    assign data_s   = pins_s.data;
    assign hold_n_s = pins_s.hold_n;

    spi_hold_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_n_s  (sel_n_s),
        .sclk_s   (sclk_s),
        .hold_n_s (hold_n_s),
        .state_o  (link_state),
        .rise_o   (edge_rise),
        .fall_o   (edge_fall),
        .clear_o  (clear)
    );

    spi_hold_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear),
        .rise_i     (edge_rise),
        .fall_i     (edge_fall),
        .data_s     (data_s),
        .tx_byte_i  (tx_byte_i),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o),
        .q_bit_o    (q_o),
        .bit_cnt_o  (bit_cnt),
        .tx_shift_o (tx_shift)
    );

    assign q_en_o = (link_state == LINK_ACTIVE);
endmodule

// File: rtl/spi_hold_checker.sv
module spi_hold_checker
    import spi_hold_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel_n_s,
    input logic              sclk_s,
    input logic              hold_n_s,
    input link_state_e       link_state,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [BYTE_W-1:0] tx_shift,
    input logic              rx_valid_o,
    input logic              q_en_o
);
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        sel_n_s |=> (link_state == LINK_IDLE && bit_cnt == '0 && !rx_valid_o && !q_en_o)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R2

    AST_STROBE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> bit_cnt == '0); // R2

    AST_PAUSE_ENTRY_OFF: assert property (@(posedge clk) disable iff (rst)
        (!sel_n_s && !sclk_s && !hold_n_s && link_state != LINK_IDLE) |=> !q_en_o); // R5

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (link_state == LINK_PAUSED && !sel_n_s) |=> ($stable(bit_cnt) && $stable(tx_shift) && !rx_valid_o)); // R6

    AST_RELEASE_WAITS_LOW: assert property (@(posedge clk) disable iff (rst)
        (link_state == LINK_PAUSED && sclk_s) |=> !q_en_o); // R8

    AST_ABORT_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (link_state == LINK_PAUSED && sel_n_s) |=> (link_state == LINK_IDLE && bit_cnt == '0)); // R9
endmodule

bind spi_hold_frontend spi_hold_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_n_s    (sel_n_s),
    .sclk_s     (sclk_s),
    .hold_n_s   (hold_n_s),
    .link_state (link_state),
    .bit_cnt    (bit_cnt),
    .tx_shift   (tx_shift),
    .rx_valid_o (rx_valid_o),
    .q_en_o     (q_en_o)
);

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1, sclk = 1'b0, din = 1'b0, hold_n = 1'b1;
    logic       q, q_en, rx_valid;
    logic [7:0] rx_byte, tx_byte = 8'h00;

    int checks = 0, fails = 0, strobes = 0;
    logic [7:0] last_rx = 8'h00;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_hold_frontend uut (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .sclk_i(sclk), .d_i(din),
        .hold_n_i(hold_n), .q_o(q), .q_en_o(q_en), .rx_byte_o(rx_byte),
        .rx_valid_o(rx_valid), .tx_byte_i(tx_byte)
    );

    always @(posedge clk) if (rx_valid) begin strobes++; last_rx = rx_byte; end

    // rx byte in [15:8], tx byte in [7:0]
    localparam logic [15:0] VEC [6] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h8001, 16'h7E81, 16'h3C96};

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one mode-0 bit: set data, sample output, raise clock, lower clock
    task automatic xbit(input logic b, output logic qb);
        din = b;
        wait_clk(HALF);
        qb = q;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] rxv, input logic [7:0] next_tx, output logic [7:0] qv);
        for (int i = 7; i >= 0; i--) begin
            logic qb;
            xbit(rxv[i], qb);
            qv[i] = qb;
            if (i == 7) tx_byte = next_tx;
        end
    endtask

    task automatic select_start(input logic [7:0] txv);
        tx_byte = txv;
        wait_clk(2);
        sel_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic deselect;
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] qv, qv2;
        int s0;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        // R1 reset state
        chk(q_en == 1'b0, "R1 q_en after reset", q_en, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid after reset", rx_valid, 0);
        chk(rx_byte == 8'h00, "R1 rx_byte after reset", rx_byte, 0);

        // vector table: R2, R3
        for (int v = 0; v < 6; v++) begin
            s0 = strobes;
            select_start(VEC[v][7:0]);
            chk(q_en == 1'b1, "R3 q_en when selected", q_en, 1);
            xbyte(VEC[v][15:8], 8'h00, qv);
            wait_clk(HALF);
            chk(last_rx == VEC[v][15:8], "R2 received byte", last_rx, VEC[v][15:8]);
            chk(strobes == s0 + 1, "R2 one strobe per byte", strobes - s0, 1);
            chk(qv == VEC[v][7:0], "R3 output bits", qv, VEC[v][7:0]);
            deselect;
            chk(q_en == 1'b0, "R1 q_en when deselected", q_en, 0);
        end

        // R4 back-to-back bytes reload transmit byte
        s0 = strobes;
        select_start(8'hC3);
        xbyte(8'h12, 8'h5A, qv);
        xbyte(8'h34, 8'h00, qv2);
        wait_clk(HALF);
        chk(qv == 8'hC3, "R4 first tx byte", qv, 8'hC3);
        chk(qv2 == 8'h5A, "R4 reloaded tx byte", qv2, 8'h5A);
        chk(last_rx == 8'h34 && strobes == s0 + 2, "R2 second rx byte", last_rx, 8'h34);
        deselect;

        // R5..R8 pauses inside one byte: rx 0xB6, tx 0x9D
        s0 = strobes;
        select_start(8'h9D);
        for (int i = 7; i >= 5; i--) begin
            logic qb;
            xbit(8'hB6 >> i, qb);
            qv[i] = qb;
        end
        // bit 4 with deferred entry (R7)
        din = 1'b1;
        wait_clk(HALF);
        qv[4] = q;
        sclk = 1'b1;
        wait_clk(HALF / 2);
        hold_n = 1'b0;
        wait_clk(HALF / 2);
        chk(q_en == 1'b1, "R7 still active while clock high", q_en, 1);
        sclk = 1'b0;
        wait_clk(HALF);
        chk(q_en == 1'b0, "R7 paused after falling edge", q_en, 0);
        chk(q == 1'b1, "R7 entry edge advanced output", q, 1); // bit 3 of 0x9D
        // R5 clock and data ignored while paused
        for (int k = 0; k < 3; k++) begin
            din = ~din;
            sclk = 1'b1; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
        end
        chk(strobes == s0, "R5 no strobe while paused", strobes - s0, 0);
        chk(q_en == 1'b0, "R5 output off while paused", q_en, 0);
        hold_n = 1'b1;
        wait_clk(HALF);
        chk(q_en == 1'b1, "R5 release with clock low", q_en, 1);
        for (int i = 3; i >= 2; i--) begin
            logic qb;
            xbit(8'hB6 >> i, qb);
            qv[i] = qb;
        end
        // entry with clock low, release while clock high (R8)
        wait_clk(HALF);
        hold_n = 1'b0;
        wait_clk(HALF);
        chk(q_en == 1'b0, "R5 paused with clock low", q_en, 0);
        sclk = 1'b1;
        wait_clk(HALF);
        hold_n = 1'b1;
        wait_clk(HALF);
        chk(q_en == 1'b0, "R8 release waits for falling edge", q_en, 0);
        sclk = 1'b0;
        wait_clk(HALF);
        chk(q_en == 1'b1, "R8 released after falling edge", q_en, 1);
        for (int i = 1; i >= 0; i--) begin
            logic qb;
            xbit(8'hB6 >> i, qb);
            qv[i] = qb;
        end
        wait_clk(HALF);
        chk(last_rx == 8'hB6 && strobes == s0 + 1, "R6 byte intact across pauses", last_rx, 8'hB6);
        chk(qv == 8'h9D, "R6 output bits intact across pauses", qv, 8'h9D);
        deselect;

        // R9 deselect while paused abandons partial byte
        s0 = strobes;
        select_start(8'hFF);
        for (int i = 0; i < 3; i++) begin
            logic qb;
            xbit(1'b1, qb);
        end
        wait_clk(HALF);
        hold_n = 1'b0;
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(HALF);
        hold_n = 1'b1;
        wait_clk(HALF);
        chk(q_en == 1'b0 && strobes == s0, "R9 abort without strobe", strobes - s0, 0);
        select_start(8'h69);
        xbyte(8'h0F, 8'h00, qv);
        wait_clk(HALF);
        chk(last_rx == 8'h0F && strobes == s0 + 1, "R9 restart from bit 7", last_rx, 8'h0F);
        chk(qv == 8'h69, "R9 output restarts", qv, 8'h69);
        deselect;

        // R10 activity while deselected
        s0 = strobes;
        hold_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            din = k[0];
            sclk = 1'b1; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1;
        wait_clk(HALF);
        chk(q_en == 1'b0 && strobes == s0, "R10 no effect while deselected", strobes - s0, 0);
        select_start(8'hE7);
        xbyte(8'h5C, 8'h00, qv);
        wait_clk(HALF);
        chk(last_rx == 8'h5C && qv == 8'hE7, "R10 normal transfer afterwards", last_rx, 8'h5C);
        deselect;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule